// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the program counter, condition codes and stack pointer of a small processor core and moves the core into and out of interrupt service routines. The core reports each instruction boundary with `insn_done`, together with the address of the next instruction and the new condition codes. At that boundary only, the sequencer checks a device request. The request is the AND of the device's ready flag and its enable flag. If the request is taken, the sequencer holds fetch off and saves the return context on an upward-growing stack in memory. It then loads the service routine address from a vector table. The vector table is indexed by the 8-bit device vector.

A return is signalled by `ret_cmd` at a boundary. The sequencer then pops the condition codes and the program counter, in the reverse order of the saves. Entries can nest, and each return unwinds one frame in last-in first-out order. Memory is a single synchronous port. A read returns its data in the cycle after the request.

The state machine has these states:
- `ST_RUN`: normal execution, fetch enabled.
- `ST_PUSH_PC`, `ST_PUSH_CC`: the two save writes.
- `ST_VEC_RD`, `ST_VEC_LD`: the table read and the PC load.
- `ST_POP_CC`, `ST_POP_PC`, `ST_POP_LD`: the two restore reads and the final PC load.

Transitions:
- RUN to PUSH_PC when a request is taken.
- RUN to POP_CC on a return boundary.
- PUSH_PC to PUSH_CC to VEC_RD to VEC_LD to RUN, unconditionally.
- POP_CC to POP_PC to POP_LD to RUN, unconditionally.
- RUN stays in RUN otherwise.

Top module: `intr_seq_top`

## Requirements
- R1: After reset, `fetch_en` is 1, `pc_out` is PC_INIT (0x3000), `cc_out` is CC_INIT (3'b010), `sp_out` is SP_INIT (0x02FF) and `mem_en` is 0.
- R2: A boundary in RUN with no taken request loads `pc_in` and `cc_in` into `pc_out` and `cc_out` on the next edge. It makes no memory access and keeps `fetch_en` at 1.
- R3: The request is `dev_ready` AND `dev_ien`, and it is sampled only when `insn_done` is 1 in RUN. A request held between boundaries, or a request with either flag at 0, has no effect on fetch, memory or registers.
- R4: A taken request drops `fetch_en` for exactly 4 cycles. It first writes the next PC (`pc_in`) at address SP+1, then writes the condition codes at address SP+2. The condition codes sit in bits [2:0] of the word and the upper bits are zero.
- R5: After the two saves, the block makes one read at VEC_BASE (0x0100) + vector. It loads `pc_out` from the returned word. At the end SP has grown by 2 and `cc_out` equals the saved value.
- R6: `ret_cmd` with `insn_done` in RUN drops `fetch_en` for exactly 3 cycles. It reads address SP and then SP-1, loads `cc_out` from bits [2:0] of the first word and `pc_out` from the second, and leaves SP reduced by 2.
- R7: When `ret_cmd` and a request coincide at one boundary, the return is performed, no write is made and the request is not taken.
- R8: Nested entries stack their frames above earlier ones, and successive returns restore them in last-in first-out order.
- R9: `ret_cmd` without `insn_done` has no effect.
- R10: Every write increments SP by one on the same edge. SP changes only during entry and return sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| ret_cmd | input | 1 | The finished instruction is a return from interrupt |
| pc_in | input | 16 | Address of the next instruction |
| cc_in | input | 3 | Condition codes after the finished instruction |
| dev_ready | input | 1 | Device ready flag |
| dev_ien | input | 1 | Device interrupt enable flag |
| dev_vector | input | 8 | Device identifying vector |
| fetch_en | output | 1 | Core may fetch the next instruction |
| pc_out | output | 16 | Program counter register |
| cc_out | output | 3 | Condition code register |
| sp_out | output | 16 | Stack pointer register |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read |

## Verification
The main function is exercised by a table of entry and return pairs. The pairs vary the vector across both ends of its range and each condition code pattern. A wrong table index or a swapped save order would therefore change the restored PC or CC. Nested entries with distinct contexts show that frames are kept apart and unwound in last-in first-out order. Requests held between boundaries and requests with only one flag set show that sampling happens only at the boundary and that the two flags are gated together. A return that coincides with a request shows which of the two wins.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PUSH_PC,
        ST_PUSH_CC,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_POP_CC,
        ST_POP_PC,
        ST_POP_LD
    } seq_state_e;

    typedef enum logic [1:0] {
        SP_KEEP,
        SP_UP,
        SP_DOWN
    } sp_op_e;

endpackage

// File: rtl/intr_seq_req.sv
module intr_seq_req #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             insn_done,
    input  logic             ret_cmd,
    input  logic             dev_ready,
    input  logic             dev_ien,
    input  logic [VEC_W-1:0] dev_vector,
    output logic             take,
    output logic             retn,
    output logic             core_ld,
    output logic [VEC_W-1:0] vec_q
);

    logic boundary;
    logic dev_req;

    // Sampling happens only at a boundary while the core runs normally.
    assign boundary = run & insn_done;
    assign dev_req  = dev_ready & dev_ien;

    // A return outranks a request at the same boundary.
    assign retn     = boundary & ret_cmd;
    assign take     = boundary & ~ret_cmd & dev_req;
    assign core_ld  = boundary & ~ret_cmd;

    // The vector is held for the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (take) begin
            vec_q <= dev_vector;
        end
    end

endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
    import intr_seq_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter int          CC_W    = 3,
    parameter logic [AW-1:0] PC_INIT = 16'h3000,
    parameter logic [AW-1:0] SP_INIT = 16'h02FF,
    parameter logic [CC_W-1:0] CC_INIT = 3'b010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_ld,
    input  logic [AW-1:0]   pc_in,
    input  logic [CC_W-1:0] cc_in,
    input  logic            pc_ld_mem,
    input  logic            cc_ld_mem,
    input  logic [DW-1:0]   mem_rdata,
    input  sp_op_e          sp_op,
    output logic [AW-1:0]   pc_q,
    output logic [CC_W-1:0] cc_q,
    output logic [AW-1:0]   sp_q
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_INIT;
        end else if (pc_ld_mem) begin
            pc_q <= mem_rdata[AW-1:0];
        end else if (core_ld) begin
            pc_q <= pc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= CC_INIT;
        end else if (cc_ld_mem) begin
            cc_q <= mem_rdata[CC_W-1:0];
        end else if (core_ld) begin
            cc_q <= cc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else begin
            unique case (sp_op)
                SP_UP:   sp_q <= sp_q + ONE;
                SP_DOWN: sp_q <= sp_q - ONE;
                default: sp_q <= sp_q;
            endcase
        end
    end

endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter int            CC_W     = 3,
    parameter int            VEC_W    = 8,
    parameter logic [AW-1:0] VEC_BASE = 16'h0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             retn,
    input  logic [AW-1:0]    pc_q,
    input  logic [CC_W-1:0]  cc_q,
    input  logic [AW-1:0]    sp_q,
    input  logic [VEC_W-1:0] vec_q,
    output logic             run,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output sp_op_e           sp_op,
    output logic             pc_ld_mem,
    output logic             cc_ld_mem
);

    localparam logic [AW-1:0] ONE = AW'(1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic [AW-1:0] push_addr;
    logic [AW-1:0] tbl_addr;

    assign push_addr = sp_q + ONE;
    assign tbl_addr  = VEC_BASE + AW'(vec_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (retn) begin
                    state_d = ST_POP_CC;
                end else if (take) begin
                    state_d = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: state_d = ST_PUSH_CC;
            ST_PUSH_CC: state_d = ST_VEC_RD;
            ST_VEC_RD:  state_d = ST_VEC_LD;
            ST_VEC_LD:  state_d = ST_RUN;
            ST_POP_CC:  state_d = ST_POP_PC;
            ST_POP_PC:  state_d = ST_POP_LD;
            ST_POP_LD:  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        run       = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        sp_op     = SP_KEEP;
        pc_ld_mem = 1'b0;
        cc_ld_mem = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run = 1'b1;
            end
            ST_PUSH_PC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = DW'(pc_q);
                sp_op     = SP_UP;
            end
            ST_PUSH_CC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = DW'(cc_q);
                sp_op     = SP_UP;
            end
            ST_VEC_RD: begin
                mem_en   = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_VEC_LD: begin
                pc_ld_mem = 1'b1;
            end
            ST_POP_CC: begin
                mem_en   = 1'b1;
                mem_addr = sp_q;
                sp_op    = SP_DOWN;
            end
            ST_POP_PC: begin
                mem_en    = 1'b1;
                mem_addr  = sp_q;
                sp_op     = SP_DOWN;
                cc_ld_mem = 1'b1;
            end
            ST_POP_LD: begin
                pc_ld_mem = 1'b1;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
    import intr_seq_pkg::*;
#(
    parameter int              AW       = 16,
    parameter int              DW       = 16,
    parameter int              CC_W     = 3,
    parameter int              VEC_W    = 8,
    parameter logic [AW-1:0]   VEC_BASE = 16'h0100,
    parameter logic [AW-1:0]   PC_INIT  = 16'h3000,
    parameter logic [AW-1:0]   SP_INIT  = 16'h02FF,
    parameter logic [CC_W-1:0] CC_INIT  = 3'b010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             ret_cmd,
    input  logic [AW-1:0]    pc_in,
    input  logic [CC_W-1:0]  cc_in,
    input  logic             dev_ready,
    input  logic             dev_ien,
    input  logic [VEC_W-1:0] dev_vector,
    output logic             fetch_en,
    output logic [AW-1:0]    pc_out,
    output logic [CC_W-1:0]  cc_out,
    output logic [AW-1:0]    sp_out,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);

    logic             run;
    logic             take;
    logic             retn;
    logic             core_ld;
    logic [VEC_W-1:0] vec_q;
    logic             pc_ld_mem;
    logic             cc_ld_mem;
    sp_op_e           sp_op;

    intr_seq_req #(
        .VEC_W (VEC_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .insn_done  (insn_done),
        .ret_cmd    (ret_cmd),
        .dev_ready  (dev_ready),
        .dev_ien    (dev_ien),
        .dev_vector (dev_vector),
        .take       (take),
        .retn       (retn),
        .core_ld    (core_ld),
        .vec_q      (vec_q)
    );

    intr_seq_fsm #(
        .AW       (AW),
        .DW       (DW),
        .CC_W     (CC_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .retn      (retn),
        .pc_q      (pc_out),
        .cc_q      (cc_out),
        .sp_q      (sp_out),
        .vec_q     (vec_q),
        .run       (run),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_op     (sp_op),
        .pc_ld_mem (pc_ld_mem),
        .cc_ld_mem (cc_ld_mem)
    );

    intr_seq_regs #(
        .AW      (AW),
        .DW      (DW),
        .CC_W    (CC_W),
        .PC_INIT (PC_INIT),
        .SP_INIT (SP_INIT),
        .CC_INIT (CC_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_ld   (core_ld),
        .pc_in     (pc_in),
        .cc_in     (cc_in),
        .pc_ld_mem (pc_ld_mem),
        .cc_ld_mem (cc_ld_mem),
        .mem_rdata (mem_rdata),
        .sp_op     (sp_op),
        .pc_q      (pc_out),
        .cc_q      (cc_out),
        .sp_q      (sp_out)
    );

    assign fetch_en = run;

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_done,
    input logic          ret_cmd,
    input logic          dev_ready,
    input logic          dev_ien,
    input logic          fetch_en,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] sp_out
);

    // R2: no memory traffic while the core runs normally
    a_r2_run_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> !mem_en);

    // R3: without a boundary, fetch stays enabled
    a_r3_no_boundary_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !insn_done) |=> fetch_en);

    // R4: a taken request writes just above the stack top next cycle
    a_r4_first_push: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && insn_done && !ret_cmd && dev_ready && dev_ien)
        |=> (!fetch_en && mem_en && mem_we && mem_addr == $past(sp_out) + AW'(1)));

    // R6: a return reads the stack top next cycle
    a_r6_first_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && insn_done && ret_cmd)
        |=> (!fetch_en && mem_en && !mem_we && mem_addr == $past(sp_out)));

    // R9: a return command off the boundary changes nothing
    a_r9_ret_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && ret_cmd && !insn_done) |=> fetch_en);

    // R10: each write moves the stack pointer up by one
    a_r10_sp_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (sp_out == $past(sp_out) + AW'(1)));

    // R10: stack pointer holds while running
    a_r10_sp_stable_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !insn_done) |=> $stable(sp_out));

endmodule

bind intr_seq_top intr_seq_chk #(
    .AW (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .ret_cmd   (ret_cmd),
    .dev_ready (dev_ready),
    .dev_ien   (dev_ien),
    .fetch_en  (fetch_en),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_out    (sp_out)
);

// File: tb/intr_seq_top_tb.sv
module intr_seq_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_done;
    logic        ret_cmd;
    logic [15:0] pc_in;
    logic [2:0]  cc_in;
    logic        dev_ready;
    logic        dev_ien;
    logic [7:0]  dev_vector;
    logic        fetch_en;
    logic [15:0] pc_out;
    logic [2:0]  cc_out;
    logic [15:0] sp_out;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_seq_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .ret_cmd    (ret_cmd),
        .pc_in      (pc_in),
        .cc_in      (cc_in),
        .dev_ready  (dev_ready),
        .dev_ien    (dev_ien),
        .dev_vector (dev_vector),
        .fetch_en   (fetch_en),
        .pc_out     (pc_out),
        .cc_out     (cc_out),
        .sp_out     (sp_out),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [15:0] tbl_word(input logic [7:0] v);
        return 16'h4000 | {4'h0, v, 4'h0};
    endfunction

    // Memory model: table region 0x100..0x1FF is computed, the rest is RAM.
    logic [15:0] ram [1024];
    logic        log_we   [16];
    logic [15:0] log_addr [16];
    logic [15:0] log_data [16];
    int          nacc = 0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                ram[mem_addr[9:0]] <= mem_wdata;
            end else if (mem_addr[15:8] == 8'h01) begin
                mem_rdata <= tbl_word(mem_addr[7:0]);
            end else begin
                mem_rdata <= ram[mem_addr[9:0]];
            end
            log_we[nacc % 16]   <= mem_we;
            log_addr[nacc % 16] <= mem_addr;
            log_data[nacc % 16] <= mem_wdata;
            nacc <= nacc + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic boundary(input logic [15:0] pc, input logic [2:0] cc, input logic ret,
                            input logic rdy, input logic ien, input logic [7:0] vec,
                            output int low);
        @(negedge clk);
        insn_done = 1'b1; ret_cmd = ret; pc_in = pc; cc_in = cc;
        dev_ready = rdy; dev_ien = ien; dev_vector = vec;
        @(negedge clk);
        insn_done = 1'b0; ret_cmd = 1'b0; dev_ready = 1'b0; dev_ien = 1'b0;
        low = 0;
        while (!fetch_en && low < 20) begin
            low++;
            @(negedge clk);
        end
    endtask

    task automatic do_entry(input logic [7:0] v, input logic [15:0] pc, input logic [2:0] cc);
        logic [15:0] s;
        int n0;
        int low;
        s  = sp_out;
        n0 = nacc;
        boundary(pc, cc, 1'b0, 1'b1, 1'b1, v, low);
        chk("R4 fetch low cycles", low, 4);
        chk("R4 access count", nacc - n0, 3);
        chk("R4 first write we", log_we[n0 % 16], 1);
        chk("R4 first write addr", log_addr[n0 % 16], s + 16'd1);
        chk("R4 first write pc", log_data[n0 % 16], pc);
        chk("R4 second write addr", log_addr[(n0 + 1) % 16], s + 16'd2);
        chk("R4 second write cc", log_data[(n0 + 1) % 16], {13'd0, cc});
        chk("R5 table read we", log_we[(n0 + 2) % 16], 0);
        chk("R5 table read addr", log_addr[(n0 + 2) % 16], 16'h0100 + {8'd0, v});
        chk("R5 pc from table", pc_out, tbl_word(v));
        chk("R5 sp grown", sp_out, s + 16'd2);
        chk("R5 cc kept", cc_out, cc);
    endtask

    task automatic do_return(input logic [15:0] pc, input logic [2:0] cc, input logic req);
        logic [15:0] s;
        int n0;
        int low;
        s  = sp_out;
        n0 = nacc;
        boundary(16'hDEAD, 3'b111, 1'b1, req, req, 8'h00, low);
        chk("R6 fetch low cycles", low, 3);
        chk("R6 access count", nacc - n0, 2);
        chk("R6 pop1 read", {log_we[n0 % 16], log_addr[n0 % 16]}, {1'b0, s});
        chk("R6 pop2 read", {log_we[(n0 + 1) % 16], log_addr[(n0 + 1) % 16]}, {1'b0, s - 16'd1});
        chk("R6 pc restored", pc_out, pc);
        chk("R6 cc restored", cc_out, cc);
        chk("R6 sp shrunk", sp_out, s - 16'd2);
    endtask

    // Scenario vectors: {vector, next pc, cc}
    localparam logic [26:0] SCEN [6] = '{
        {8'h00, 16'h3007, 3'b001},
        {8'hFF, 16'h3100, 3'b100},
        {8'h80, 16'hABCD, 3'b010},
        {8'h01, 16'h0000, 3'b000},
        {8'h7E, 16'hFFFF, 3'b111},
        {8'h3C, 16'h5A5A, 3'b101}
    };

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        int low;
        logic [15:0] p0;
        rst_n = 1'b0; insn_done = 1'b0; ret_cmd = 1'b0; pc_in = '0; cc_in = '0;
        dev_ready = 1'b0; dev_ien = 1'b0; dev_vector = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 fetch_en", fetch_en, 1);
        chk("R1 pc", pc_out, 16'h3000);
        chk("R1 cc", cc_out, 3'b010);
        chk("R1 sp", sp_out, 16'h02FF);
        chk("R1 mem_en", mem_en, 0);

        // R2 plain boundary
        n0 = nacc;
        boundary(16'h3010, 3'b100, 1'b0, 1'b0, 1'b0, 8'h05, low);
        chk("R2 no stall", low, 0);
        chk("R2 pc loaded", pc_out, 16'h3010);
        chk("R2 cc loaded", cc_out, 3'b100);
        chk("R2 no access", nacc - n0, 0);

        // Main table walk: entry then return
        for (int i = 0; i < 6; i++) begin
            do_entry(SCEN[i][26:19], SCEN[i][18:3], SCEN[i][2:0]);
            do_return(SCEN[i][18:3], SCEN[i][2:0], 1'b0);
        end

        // R3 request held between boundaries
        n0 = nacc;
        p0 = pc_out;
        low = 0;
        @(negedge clk);
        dev_ready = 1'b1; dev_ien = 1'b1; dev_vector = 8'h22;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!fetch_en) low++;
        end
        dev_ready = 1'b0; dev_ien = 1'b0;
        chk("R3 held request no stall", low, 0);
        chk("R3 held request no access", nacc - n0, 0);
        chk("R3 held request pc", pc_out, p0);

        // R3 one flag only
        n0 = nacc;
        boundary(16'h3456, 3'b001, 1'b0, 1'b1, 1'b0, 8'h11, low);
        chk("R3 ready only no stall", low, 0);
        chk("R3 ready only pc", pc_out, 16'h3456);
        boundary(16'h3457, 3'b100, 1'b0, 1'b0, 1'b1, 8'h11, low);
        chk("R3 enable only no stall", low, 0);
        chk("R3 enable only no access", nacc - n0, 0);

        // R8 nesting
        do_entry(8'h10, 16'h3101, 3'b001);
        do_entry(8'h20, 16'h4105, 3'b100);
        chk("R8 nested sp", sp_out, 16'h02FF + 16'd4);
        do_return(16'h4105, 3'b100, 1'b0);
        do_return(16'h3101, 3'b001, 1'b0);

        // R7 return with simultaneous request
        do_entry(8'h42, 16'h3333, 3'b010);
        n0 = nacc;
        do_return(16'h3333, 3'b010, 1'b1);
        chk("R7 no write on combined boundary", log_we[n0 % 16] | log_we[(n0 + 1) % 16], 0);

        // R9 return command without boundary
        n0 = nacc;
        p0 = pc_out;
        @(negedge clk);
        ret_cmd = 1'b1;
        @(negedge clk);
        ret_cmd = 1'b0;
        @(negedge clk);
        chk("R9 fetch still on", fetch_en, 1);
        chk("R9 no access", nacc - n0, 0);
        chk("R9 pc kept", pc_out, p0);
        chk("R10 sp at base", sp_out, 16'h02FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule